// File: doc/BRIEF.md
# CAN idle start-of-frame glitch filter

This block watches the receive line of a CAN controller while the bus is idle. It decides whether a dominant level is the start of a frame or a short disturbance that must be thrown away. A dominant level counts as a start of frame only once it has lasted a whole synchronisation quantum plus the first timing segment. That span is computed from the programmed prescaler, propagation segment and phase-1 segment. Any shorter dominant pulse leaves the block idle.

When a start of frame is accepted, the block emits a one-cycle pulse, drops its bus-idle flag and raises its receiver flag. Both flags keep their values until the frame logic downstream asserts a re-arm input, which returns the block to idle. The receive input passes through a two-flop synchroniser before it is counted. The timing fields are sampled only while the idle line is recessive, so a field that changes during a dominant run cannot alter the threshold of that run.

Top module: `can_sof_filter`

## Requirements
- R1: After reset, and as long as no dominant level has been accepted, bus_idle is 1, receiver is 0 and sof_pulse is 0.
- R2: A dominant level is rx_in = 0 and a recessive level is rx_in = 1. While idle, a dominant level sampled on at least T consecutive clock edges is accepted as a start of frame, where T = P × (1 + prop_seg + ph1_seg) and P is the programmed prescaler.
- R3: A dominant pulse shorter than T edges, whether it is one time quantum (P cycles) short or one cycle short, is ignored: bus_idle stays 1, receiver stays 0 and no sof_pulse occurs.
- R4: Any recessive sample during a dominant run clears the count. Two dominant pulses, each shorter than T and separated by a single recessive cycle, are not accepted.
- R5: On acceptance, sof_pulse is high for exactly one cycle. In that same cycle bus_idle falls to 0 and receiver rises to 1.
- R6: After acceptance, bus_idle = 0 and receiver = 1 hold whatever rx_in does until rearm is sampled high. The cycle after that sample, bus_idle is 1 and receiver is 0.
- R7: The timing fields are captured only while idle with a recessive synchronised line. A change of the fields during a dominant run does not change the threshold used for that run. The new values take effect after the line returns recessive.
- R8: If rx_in is first sampled dominant on clock edge k and stays dominant, sof_pulse is high after edge k + T + 1. This is the two-flop synchroniser delay plus T.
- R9: A prescaler value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_in | input | 1 | Asynchronous CAN receive line, 0 = dominant |
| presc | input | PRESC_W | Time-quantum prescaler in system cycles (0 acts as 1) |
| prop_seg | input | PROP_W | Propagation segment in time quanta |
| ph1_seg | input | PH1_W | Phase segment 1 in time quanta |
| rearm | input | 1 | End of frame, return to idle and re-arm the filter |
| bus_idle | output | 1 | Bus idle flag |
| receiver | output | 1 | Receiver role flag |
| sof_pulse | output | 1 | One-cycle start-of-frame indication |

## Verification
The hardest case to reach is a change of the timing fields in the middle of a dominant run. The bench first lets a long threshold be captured. It then starts a dominant run and lowers the prescaler after a few cycles, so that the run is already longer than the new, shorter threshold but still shorter than the captured one. The run must be rejected. A later run that matches the new threshold must be accepted. Glitch accumulation is covered by two sub-threshold pulses separated by one recessive cycle, which the synchroniser passes through unchanged.

// File: rtl/can_sof_pkg.sv
package can_sof_pkg;

    localparam int PRESC_W_DEF = 8;
    localparam int PROP_W_DEF  = 7;
    localparam int PH1_W_DEF   = 6;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RECV = 1'b1
    } sof_state_e;

    // Width of 1 + prop + ph1 for the given field widths.
    function automatic int seg_sum_w(input int pw, input int hw);
        return ((pw > hw) ? pw : hw) + 2;
    endfunction

endpackage

// File: rtl/can_sof_sync.sv
module can_sof_sync #(
    parameter int       STAGES    = 2,
    parameter logic     RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RESET_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/can_sof_timing.sv
module can_sof_timing
    import can_sof_pkg::*;
#(
    parameter int PRESC_W = PRESC_W_DEF,
    parameter int PROP_W  = PROP_W_DEF,
    parameter int PH1_W   = PH1_W_DEF,
    localparam int SUM_W  = seg_sum_w(PROP_W, PH1_W),
    localparam int THR_W  = PRESC_W + SUM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cap_en,
    input  logic [PRESC_W-1:0] presc,
    input  logic [PROP_W-1:0]  prop_seg,
    input  logic [PH1_W-1:0]   ph1_seg,
    output logic [THR_W-1:0]   thr
);
    logic [PRESC_W-1:0] eff_presc;
    logic [SUM_W-1:0]   seg_quanta;
    logic [THR_W-1:0]   thr_next;
    logic [THR_W-1:0]   thr_q;

    always_comb begin
        eff_presc  = (presc == '0) ? PRESC_W'(1) : presc;
        seg_quanta = SUM_W'(1) + SUM_W'(prop_seg) + SUM_W'(ph1_seg);
        thr_next   = THR_W'(eff_presc) * THR_W'(seg_quanta);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            thr_q <= '1;
        end else if (cap_en) begin
            thr_q <= thr_next;
        end
    end

    assign thr = thr_q;

    // R7: threshold frozen whenever capture is not enabled
    p_frozen_r7: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(thr_q));

    // R9: threshold never collapses to zero, even with a zero prescaler
    p_thr_nonzero_r9: assert property (@(posedge clk) disable iff (rst)
        thr_q != '0);
endmodule

// File: rtl/can_sof_detect.sv
module can_sof_detect
    import can_sof_pkg::*;
#(
    parameter int THR_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rx_s,
    input  logic             rearm,
    input  logic [THR_W-1:0] thr,
    output logic             cap_en,
    output logic             bus_idle,
    output logic             receiver,
    output logic             sof_pulse
);
    sof_state_e       state;
    logic [THR_W-1:0] cnt;
    logic             sof_q;
    logic             hit;

    assign hit = (cnt == thr - THR_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            sof_q <= 1'b0;
        end else begin
            sof_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (!rx_s) begin
                        if (hit) begin
                            state <= ST_RECV;
                            sof_q <= 1'b1;
                            cnt   <= '0;
                        end else begin
                            cnt <= cnt + THR_W'(1);
                        end
                    end else begin
                        cnt <= '0;
                    end
                end
                ST_RECV: begin
                    cnt <= '0;
                    if (rearm) begin
                        state <= ST_IDLE;
                    end
                end
                default: begin
                    state <= ST_IDLE;
                    cnt   <= '0;
                end
            endcase
        end
    end

    assign cap_en    = (state == ST_IDLE) && rx_s;
    assign bus_idle  = (state == ST_IDLE);
    assign receiver  = (state == ST_RECV);
    assign sof_pulse = sof_q;

    // R5: start-of-frame indication lasts one cycle only
    p_sof_single_r5: assert property (@(posedge clk) disable iff (rst)
        sof_q |=> !sof_q);

    // R2: acceptance only follows a dominant synchronised sample
    p_sof_after_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sof_q) |-> $past(!rx_s));

    // R6: receiver role persists until re-armed
    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (receiver && !rearm) |=> receiver);

    // R4: recessive sample while idle clears the count
    p_clear_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_idle && rx_s) |=> (cnt == '0));

    // R3: idle count stays below the captured threshold
    p_below_thr_r3: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> (cnt < thr));
endmodule

// File: rtl/can_sof_filter.sv
module can_sof_filter
    import can_sof_pkg::*;
#(
    parameter int PRESC_W = PRESC_W_DEF,
    parameter int PROP_W  = PROP_W_DEF,
    parameter int PH1_W   = PH1_W_DEF,
    localparam int SUM_W  = seg_sum_w(PROP_W, PH1_W),
    localparam int THR_W  = PRESC_W + SUM_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rx_in,
    input  logic [PRESC_W-1:0] presc,
    input  logic [PROP_W-1:0]  prop_seg,
    input  logic [PH1_W-1:0]   ph1_seg,
    input  logic               rearm,
    output logic               bus_idle,
    output logic               receiver,
    output logic               sof_pulse
);
    logic             rx_s;
    logic             cap_en;
    logic [THR_W-1:0] thr;

    can_sof_sync #(
        .STAGES    (2),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (rx_in),
        .q_sync  (rx_s)
    );

    can_sof_timing #(
        .PRESC_W (PRESC_W),
        .PROP_W  (PROP_W),
        .PH1_W   (PH1_W)
    ) u_timing (
        .clk      (clk),
        .rst      (rst),
        .cap_en   (cap_en),
        .presc    (presc),
        .prop_seg (prop_seg),
        .ph1_seg  (ph1_seg),
        .thr      (thr)
    );

    can_sof_detect #(
        .THR_W (THR_W)
    ) u_detect (
        .clk       (clk),
        .rst       (rst),
        .rx_s      (rx_s),
        .rearm     (rearm),
        .thr       (thr),
        .cap_en    (cap_en),
        .bus_idle  (bus_idle),
        .receiver  (receiver),
        .sof_pulse (sof_pulse)
    );
endmodule

// File: tb/can_sof_filter_test.sv
module can_sof_filter_test;

    localparam int PRESC_W = 8;
    localparam int PROP_W  = 7;
    localparam int PH1_W   = 6;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               rx_in = 1'b1;
    logic [PRESC_W-1:0] presc = '0;
    logic [PROP_W-1:0]  prop_seg = '0;
    logic [PH1_W-1:0]   ph1_seg = '0;
    logic               rearm = 1'b0;
    logic               bus_idle;
    logic               receiver;
    logic               sof_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int sof_cnt = 0;
    int sof_cyc = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    can_sof_filter #(
        .PRESC_W (PRESC_W),
        .PROP_W  (PROP_W),
        .PH1_W   (PH1_W)
    ) uut (
        .clk       (clk),
        .rst       (rst),
        .rx_in     (rx_in),
        .presc     (presc),
        .prop_seg  (prop_seg),
        .ph1_seg   (ph1_seg),
        .rearm     (rearm),
        .bus_idle  (bus_idle),
        .receiver  (receiver),
        .sof_pulse (sof_pulse)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (sof_pulse) begin
            sof_cnt <= sof_cnt + 1;
            sof_cyc <= cyc;
        end
    end

    typedef struct packed {
        int presc;
        int prop;
        int ph1;
        int len;
        bit acc;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VEC [NV] = '{
        '{2, 3, 2, 10, 1'b0},
        '{2, 3, 2, 11, 1'b0},
        '{2, 3, 2, 12, 1'b1},
        '{1, 0, 0, 1,  1'b1},
        '{4, 1, 1, 8,  1'b0},
        '{4, 1, 1, 12, 1'b1},
        '{0, 2, 1, 3,  1'b0},
        '{0, 2, 1, 4,  1'b1},
        '{3, 5, 4, 29, 1'b0},
        '{3, 5, 4, 40, 1'b1}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic idle_wait(input int n);
        rx_in = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic low_for(input int n);
        for (int i = 0; i < n; i++) begin
            rx_in = 1'b0;
            @(negedge clk);
        end
        rx_in = 1'b1;
    endtask

    task automatic do_rearm;
        rearm = 1'b1;
        @(negedge clk);
        rearm = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired, run did not complete");
            finish_run();
        end
    end

    initial begin
        int base;
        int start;
        int thr;
        int p;

        // Reset state
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1", "bus_idle after reset", int'(bus_idle), 1);
        check("R1", "receiver after reset", int'(receiver), 0);
        check("R1", "sof_pulse after reset", int'(sof_pulse), 0);

        // Table-driven run
        for (int v = 0; v < NV; v++) begin
            presc    = PRESC_W'(VEC[v].presc);
            prop_seg = PROP_W'(VEC[v].prop);
            ph1_seg  = PH1_W'(VEC[v].ph1);
            p   = (VEC[v].presc == 0) ? 1 : VEC[v].presc;
            thr = p * (1 + VEC[v].prop + VEC[v].ph1);
            idle_wait(4);
            base  = sof_cnt;
            start = cyc;
            low_for(VEC[v].len);
            repeat (5) @(negedge clk);
            if (VEC[v].acc) begin
                check("R2", $sformatf("vec %0d sof count", v), sof_cnt - base, 1);
                check("R5", $sformatf("vec %0d bus_idle low", v), int'(bus_idle), 0);
                check("R5", $sformatf("vec %0d receiver high", v), int'(receiver), 1);
                check("R8", $sformatf("vec %0d sof latency", v), sof_cyc - start, thr + 2);
                if (VEC[v].presc == 0)
                    check("R9", "zero prescaler accepted at T", sof_cnt - base, 1);
                do_rearm();
                check("R6", $sformatf("vec %0d idle after rearm", v), int'(bus_idle), 1);
                check("R6", $sformatf("vec %0d receiver after rearm", v), int'(receiver), 0);
            end else begin
                check("R3", $sformatf("vec %0d no sof", v), sof_cnt - base, 0);
                check("R3", $sformatf("vec %0d still idle", v), int'(bus_idle), 1);
                check("R3", $sformatf("vec %0d not receiver", v), int'(receiver), 0);
                if (VEC[v].presc == 0)
                    check("R9", "zero prescaler rejects T-1", sof_cnt - base, 0);
            end
        end

        // R4: two short pulses with a one-cycle recessive gap
        presc = 8'd2; prop_seg = 7'd3; ph1_seg = 6'd2;
        idle_wait(4);
        base = sof_cnt;
        low_for(8);
        @(negedge clk);
        low_for(8);
        repeat (5) @(negedge clk);
        check("R4", "split glitches no sof", sof_cnt - base, 0);
        check("R4", "split glitches still idle", int'(bus_idle), 1);

        // R6: line activity while receiving is ignored
        idle_wait(4);
        low_for(12);
        repeat (4) @(negedge clk);
        base = sof_cnt;
        low_for(30);
        idle_wait(3);
        low_for(20);
        idle_wait(3);
        check("R6", "no extra sof while receiving", sof_cnt - base, 0);
        check("R6", "receiver held", int'(receiver), 1);
        check("R6", "bus_idle held low", int'(bus_idle), 0);
        do_rearm();
        check("R6", "rearm restores idle", int'(bus_idle), 1);

        // R7: prescaler lowered mid-run must not shorten the threshold
        presc = 8'd2; prop_seg = 7'd3; ph1_seg = 6'd2;
        idle_wait(4);
        base = sof_cnt;
        for (int i = 0; i < 9; i++) begin
            rx_in = 1'b0;
            if (i == 3) presc = 8'd1;
            @(negedge clk);
        end
        rx_in = 1'b1;
        repeat (5) @(negedge clk);
        check("R7", "mid-run change no sof", sof_cnt - base, 0);
        check("R7", "mid-run change still idle", int'(bus_idle), 1);
        idle_wait(4);
        base  = sof_cnt;
        start = cyc;
        low_for(6);
        repeat (5) @(negedge clk);
        check("R7", "new threshold applied", sof_cnt - base, 1);
        check("R7", "new threshold latency", sof_cyc - start, 8);
        do_rearm();

        // R1: reset from the receiving state
        idle_wait(4);
        low_for(6);
        repeat (4) @(negedge clk);
        check("R5", "receiver before reset", int'(receiver), 1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", "bus_idle after mid-run reset", int'(bus_idle), 1);
        check("R1", "receiver after mid-run reset", int'(receiver), 0);

        done = 1'b1;
        finish_run();
    end
endmodule